// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital side of a successive-approximation analog-to-digital converter. Software programs a small register file with the scan mode, the channel (or the last channel of a sweep), the result width, the sample-and-hold option and a conversion clock divisor. A conversion then runs a binary search. Each trial code goes out on `dac_code` while `chan_sel` names the analog input. The external comparator answers on `cmp_in`, and each finished result lands in that channel's result register.

A conversion starts in one of two ways. In software mode it starts when the start flag goes from 0 to 1. In external mode it starts on a falling edge of the active-low trigger while the flag is held at 1, and a new falling edge during a pass restarts it. Nothing starts unless the reference-connect bit is set. That bit also drives `ladder_en` to the analog ladder. Five scan modes cover a single channel or an ascending sweep, each either once or continuously. One continuous sweep interleaves channel 0 between every other channel.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, both control bytes (address 0x20 and 0x21) and every result byte read 0, and `busy`, `done_irq`, `dac_code` and `ladder_en` are 0.
- R2: With the external bit (0x20 bit 3) clear, writing the start flag (0x20 bit 4) from 0 to 1 starts a conversion only if the reference bit (0x20 bit 5) is 1 in the same write. With the reference bit clear, `busy` stays 0 and `ladder_en` is 0.
- R3: One channel keeps `busy` high for B×D clock cycles. B is 49 (8-bit, no sample-and-hold), 59 (10-bit, no sample-and-hold), 28 (8-bit, sample-and-hold) or 33 (10-bit, sample-and-hold). D is 1, 2 or 4 for divisor field 0x21 bits 5:4 = 0, 1 or 2 (3 also gives 4). Bit 6 of 0x20 selects 10-bit and bit 7 enables sample-and-hold.
- R4: The search tests one bit per step from MSB to LSB, presenting the trial code on `dac_code`. It keeps the bit when `cmp_in` is 1, meaning the input is at or above the trial. The 10-bit result is the largest code not above the input. `dac_code` is 0 while idle.
- R5: In 8-bit mode the result is the top 8 bits of the input, `dac_code[9:8]` stays 0, and only the channel's even byte is written. The odd byte keeps its previous value.
- R6: Channel k's result is read at byte address 2k (bits 7:0) and 2k+1 (bits 9:8 in bits 1:0, other bits 0). Channels 8 and 9 are the extended inputs.
- R7: Mode 0 (one-shot, 0x20 bits 2:0) converts channel 0x21 bits 3:0 once. It then pulses `done_irq` for exactly one cycle as `busy` falls, and the start flag reads back 0.
- R8: Mode 1 (repeat) converts the same channel again and again with no `done_irq`. Clearing the start flag stops it within one cycle.
- R9: Mode 2 (single sweep) converts channels 0 up to the programmed last channel in ascending order, writing each result. It then gives one `done_irq` and clears the start flag.
- R10: Mode 3 (repeat sweep 0) cycles through channels 0..last without end and without `done_irq`.
- R11: Mode 4 (repeat sweep 1) alternates channel 0 with each other channel in turn: 0,1,0,2,...,0,last, then again from 0,1.
- R12: With the external bit set, a falling edge on `trig_n` starts a conversion only while the start flag is 1, and writing the flag does not start one. The edge reaches `busy` three clock edges after the first low sample.
- R13: A new falling edge on `trig_n` during a conversion restarts it from the first step. `busy` stays high for the gap between the two edges plus one full budget, with one `done_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| trig_n | input | 1 | External active-low trigger, asynchronous |
| cmp_in | input | 1 | Comparator answer: input at or above `dac_code` |
| chan_sel | output | CH_W | Analog channel being converted |
| dac_code | output | RES_W | Trial code for the comparator |
| ladder_en | output | 1 | Connect the reference to the ladder |
| busy | output | 1 | Conversion in progress |
| done_irq | output | 1 | One-cycle end-of-pass pulse |

## Verification
The search is tried with full-scale, zero-scale, alternating-bit and arbitrary input levels. These separate a wrong keep/clear decision, a step off by one bit, and a result whose 8-bit form is shifted wrongly. Each scan mode runs with distinct input levels per channel, and the logged channel order tells the three sweep orderings apart. Busy-time counts over all four budget pairs and all three divisors expose any wrong budget or divisor. The trigger tests compare an edge with the flag clear, a flag write in external mode, and a second edge mid-conversion, whose exact busy length shows whether the pass really restarted.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    localparam int NUM_CH_DEF = 10;
    localparam int CH_W       = 4;
    localparam int RES_W      = 10;
    localparam int CNT_W      = 6;
    localparam int CTRL0_ADDR = 'h20;
    localparam int CTRL1_ADDR = 'h21;

    localparam logic [CNT_W-1:0] BUDGET_8_PLAIN  = CNT_W'(49);
    localparam logic [CNT_W-1:0] BUDGET_10_PLAIN = CNT_W'(59);
    localparam logic [CNT_W-1:0] BUDGET_8_SH     = CNT_W'(28);
    localparam logic [CNT_W-1:0] BUDGET_10_SH    = CNT_W'(33);

    typedef enum logic [2:0] {
        MODE_ONESHOT = 3'd0,
        MODE_REPEAT  = 3'd1,
        MODE_SWEEP   = 3'd2,
        MODE_RSWEEP0 = 3'd3,
        MODE_RSWEEP1 = 3'd4
    } adc_mode_e;

    typedef struct packed {
        logic            sh;
        logic            res10;
        logic            vref;
        logic            start;
        logic            ext;
        adc_mode_e       mode;
        logic [1:0]      div;
        logic [CH_W-1:0] chan;
    } cfg_t;

    function automatic logic [CNT_W-1:0] chan_budget(input logic res10, input logic sh);
        case ({sh, res10})
            2'b00:   return BUDGET_8_PLAIN;
            2'b01:   return BUDGET_10_PLAIN;
            2'b10:   return BUDGET_8_SH;
            default: return BUDGET_10_SH;
        endcase
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIV_MAX = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int CW = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        case (sel)
            2'd0:    lim = '0;
            2'd1:    lim = CW'(1);
            default: lim = CW'(DIV_MAX - 1);
        endcase
        tick = (cnt_q == lim);
        if (restart || cnt_q >= lim) cnt_d = '0;
        else                         cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_n,
    output logic fall
);
    logic [SYNC:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SYNC-1:0], trig_n};
        fall = sh_q[SYNC] & ~sh_q[SYNC-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/adc_regs.sv
module adc_regs
    import sar_adc_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              res_we,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [RES_W-1:0]  res_val,
    input  logic              res_is10,
    input  logic              clr_start,
    output cfg_t              cfg,
    output logic              sw_start
);
    typedef struct packed {
        cfg_t                          cfg;
        logic [NUM_CH-1:0][RES_W-1:0]  res;
    } regs_t;

    regs_t d, q;
    logic  wr_c0, wr_c1;

    always_comb begin
        wr_c0 = wr && (addr == ADDR_W'(CTRL0_ADDR));
        wr_c1 = wr && (addr == ADDR_W'(CTRL1_ADDR));
        d = q;
        if (clr_start) d.cfg.start = 1'b0;
        if (wr_c0) begin
            d.cfg.mode  = adc_mode_e'(wdata[2:0]);
            d.cfg.ext   = wdata[3];
            d.cfg.start = wdata[4];
            d.cfg.vref  = wdata[5];
            d.cfg.res10 = wdata[6];
            d.cfg.sh    = wdata[7];
        end
        if (wr_c1) begin
            d.cfg.chan = wdata[CH_W-1:0];
            d.cfg.div  = wdata[5:4];
        end
        for (int k = 0; k < NUM_CH; k++) begin
            if (res_we && res_chan == CH_W'(k)) begin
                d.res[k][7:0] = res_val[7:0];
                if (res_is10) d.res[k][RES_W-1:8] = res_val[RES_W-1:8];
            end
        end
        sw_start = wr_c0 && wdata[4] && !q.cfg.start && wdata[5] && !wdata[3];

        rdata = 8'h00;
        if (addr == ADDR_W'(CTRL0_ADDR))
            rdata = {q.cfg.sh, q.cfg.res10, q.cfg.vref, q.cfg.start, q.cfg.ext, q.cfg.mode};
        else if (addr == ADDR_W'(CTRL1_ADDR))
            rdata = {2'b00, q.cfg.div, q.cfg.chan};
        for (int k = 0; k < NUM_CH; k++) begin
            if (addr == ADDR_W'(2 * k))     rdata = q.res[k][7:0];
            if (addr == ADDR_W'(2 * k + 1)) rdata = 8'(q.res[k][RES_W-1:8]);
        end
        cfg = q.cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import sar_adc_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  adc_mode_e        mode,
    input  logic             ext,
    input  logic             start_flag,
    input  logic             vref,
    input  logic             res10,
    input  logic             sh,
    input  logic [CH_W-1:0]  last_chan,
    input  logic             sw_start,
    input  logic             trig_fall,
    input  logic             tick,
    input  logic             cmp,
    output logic             busy,
    output logic [CH_W-1:0]  chan_sel,
    output logic [RES_W-1:0] dac_code,
    output logic             res_we,
    output logic [CH_W-1:0]  res_chan,
    output logic [RES_W-1:0] res_val,
    output logic             clr_start,
    output logic             done_irq,
    output logic             div_restart
);
    typedef struct packed {
        logic             busy;
        logic [CH_W-1:0]  chan;
        logic [CH_W-1:0]  other;
        logic [CNT_W-1:0] cnt;
        logic [RES_W-1:0] sar;
        logic             done;
    } seq_t;

    localparam logic [CH_W-1:0] TOP_CH = CH_W'(NUM_CH - 1);

    seq_t d, q;
    logic [CNT_W-1:0] budget, width, first_step, bitpos;
    logic             in_steps, start_req, at_last, sweep_end;
    logic [RES_W-1:0] trial, sar_next;

    always_comb begin
        budget     = chan_budget(res10, sh);
        width      = res10 ? CNT_W'(10) : CNT_W'(8);
        first_step = budget - width;
        bitpos     = budget - CNT_W'(1) - q.cnt;
        in_steps   = q.busy && (q.cnt >= first_step);
        trial      = in_steps ? (q.sar | (RES_W'(1) << bitpos)) : q.sar;
        sar_next   = (in_steps && cmp) ? trial : q.sar;
        at_last    = (q.cnt == budget - CNT_W'(1));
        sweep_end  = (q.chan >= last_chan) || (q.chan == TOP_CH);
        start_req  = vref && (sw_start || (ext && start_flag && trig_fall));

        d         = q;
        d.done    = 1'b0;
        res_we    = 1'b0;
        clr_start = 1'b0;

        if (start_req) begin
            d.busy  = 1'b1;
            d.chan  = (mode == MODE_ONESHOT || mode == MODE_REPEAT) ? last_chan : '0;
            d.other = CH_W'(1);
            d.cnt   = '0;
            d.sar   = '0;
        end else if (q.busy && !start_flag) begin
            d.busy = 1'b0;
            d.cnt  = '0;
            d.sar  = '0;
        end else if (q.busy && tick) begin
            d.sar = sar_next;
            if (!at_last) begin
                d.cnt = q.cnt + CNT_W'(1);
            end else begin
                res_we = 1'b1;
                d.cnt  = '0;
                d.sar  = '0;
                case (mode)
                    MODE_REPEAT: ;
                    MODE_SWEEP: begin
                        if (sweep_end) begin
                            d.busy    = 1'b0;
                            d.done    = 1'b1;
                            clr_start = 1'b1;
                        end else begin
                            d.chan = q.chan + CH_W'(1);
                        end
                    end
                    MODE_RSWEEP0: d.chan = sweep_end ? '0 : q.chan + CH_W'(1);
                    MODE_RSWEEP1: begin
                        if (q.chan == '0) begin
                            d.chan = (last_chan == '0) ? '0 : q.other;
                        end else begin
                            d.chan  = '0;
                            d.other = sweep_end ? CH_W'(1) : q.chan + CH_W'(1);
                        end
                    end
                    default: begin
                        d.busy    = 1'b0;
                        d.done    = 1'b1;
                        clr_start = 1'b1;
                    end
                endcase
            end
        end

        busy        = q.busy;
        chan_sel    = q.chan;
        dac_code    = q.busy ? trial : '0;
        res_chan    = q.chan;
        res_val     = sar_next;
        done_irq    = q.done;
        div_restart = start_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int NUM_CH      = NUM_CH_DEF,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_MAX     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              trig_n,
    input  logic              cmp_in,
    output logic [CH_W-1:0]   chan_sel,
    output logic [RES_W-1:0]  dac_code,
    output logic              ladder_en,
    output logic              busy,
    output logic              done_irq
);
    cfg_t             cfg;
    logic             sw_start, trig_fall, tick, div_restart;
    logic             res_we, clr_start;
    logic [CH_W-1:0]  res_chan;
    logic [RES_W-1:0] res_val;

    adc_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .res_we(res_we), .res_chan(res_chan), .res_val(res_val),
        .res_is10(cfg.res10), .clr_start(clr_start), .cfg(cfg), .sw_start(sw_start)
    );

    adc_trig_sync #(.SYNC(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .fall(trig_fall)
    );

    adc_clk_div #(.DIV_MAX(DIV_MAX)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(div_restart), .sel(cfg.div), .tick(tick)
    );

    adc_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk(clk), .rst_n(rst_n), .mode(cfg.mode), .ext(cfg.ext), .start_flag(cfg.start),
        .vref(cfg.vref), .res10(cfg.res10), .sh(cfg.sh), .last_chan(cfg.chan),
        .sw_start(sw_start), .trig_fall(trig_fall), .tick(tick), .cmp(cmp_in),
        .busy(busy), .chan_sel(chan_sel), .dac_code(dac_code), .res_we(res_we),
        .res_chan(res_chan), .res_val(res_val), .clr_start(clr_start),
        .done_irq(done_irq), .div_restart(div_restart)
    );

    assign ladder_en = cfg.vref;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk
    import sar_adc_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done_irq,
    input logic [RES_W-1:0] dac_code,
    input logic [CH_W-1:0]  chan_sel,
    input logic             ladder_en,
    input logic             res10
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !busy);

    // R2
    vref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ladder_en);

    // R5
    narrow_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !res10) |-> (dac_code[RES_W-1:8] == '0));

    // R4
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == '0));

    // R9
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_sel < CH_W'(NUM_CH));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done_irq(done_irq), .dac_code(dac_code),
    .chan_sel(chan_sel), .ladder_en(ladder_en), .res10(cfg.res10)
);

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;
    import sar_adc_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, reg_wr, trig_n, cmp_in, ladder_en, busy, done_irq;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [3:0] chan_sel;
    logic [9:0] dac_code;
    logic [9:0] analog [10];
    logic       bench_res10;
    logic [9:0] level;

    int tests = 0, fails = 0;
    int log_ch [64];
    int log_n = 0, done_cnt = 0, busy_total = 0;
    logic prev_busy = 1'b0;
    logic [3:0] prev_ch = '0;

    sar_adc_ctrl u_sar_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_n(trig_n), .cmp_in(cmp_in),
        .chan_sel(chan_sel), .dac_code(dac_code), .ladder_en(ladder_en),
        .busy(busy), .done_irq(done_irq)
    );

    // comparator model: 1 when the input is at or above the trial code
    always_comb begin
        level  = (chan_sel < 4'd10) ? analog[chan_sel] : 10'd0;
        cmp_in = bench_res10 ? (level >= dac_code) : ({2'b00, level[9:2]} >= dac_code);
    end

    always @(negedge clk) begin
        if (busy && (!prev_busy || chan_sel != prev_ch) && log_n < 64) begin
            log_ch[log_n] = int'(chan_sel);
            log_n++;
        end
        if (done_irq) done_cnt++;
        if (busy) busy_total++;
        prev_busy = busy;
        prev_ch   = chan_sel;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] c0(input int mode, input bit ext, input bit start,
                                      input bit vref, input bit r10, input bit sh);
        return {sh, r10, vref, start, ext, 3'(mode)};
    endfunction

    task automatic wr(input int a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = 6'(a);
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wait_idle(output int cyc);
        int guard = 0;
        cyc = 0;
        while (busy && guard < 20000) begin
            cyc++; guard++;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_lo(input logic [9:0] v, input bit r10);
        return r10 ? int'(v[7:0]) : int'(v[9:2]);
    endfunction

    task automatic t_reset();
        int v;
        rd(CTRL0_ADDR, v); check(v == 0, "R1 ctrl0", v, 0);
        rd(CTRL1_ADDR, v); check(v == 0, "R1 ctrl1", v, 0);
        rd(0, v);  check(v == 0, "R1 res0 lo", v, 0);
        rd(19, v); check(v == 0, "R1 res9 hi", v, 0);
        check(!busy && !done_irq && dac_code == 0 && !ladder_en, "R1 outputs",
              int'({busy, done_irq, ladder_en}), 0);
    endtask

    task automatic t_no_vref();
        int n0 = log_n;
        wr(CTRL0_ADDR, c0(0, 0, 1, 0, 1, 0));
        idle(80);
        check(log_n == n0 && !busy, "R2 start without reference", log_n - n0, 0);
        check(!ladder_en, "R2 ladder off", int'(ladder_en), 0);
        wr(CTRL0_ADDR, 8'h00);
    endtask

    task automatic t_oneshot(input bit r10, input bit sh, input int div, input int ch,
                             input logic [9:0] val, input int exp_cyc, input int exp_hi);
        int cyc, v, d0;
        bench_res10 = r10;
        analog[ch]  = val;
        wr(CTRL1_ADDR, 8'((div << 4) | ch));
        wr(CTRL0_ADDR, c0(0, 0, 0, 1, r10, sh));
        d0 = done_cnt;
        wr(CTRL0_ADDR, c0(0, 0, 1, 1, r10, sh));
        wait_idle(cyc);
        idle(1);
        check(cyc == exp_cyc, "R3 busy cycles", cyc, exp_cyc);
        check(done_cnt - d0 == 1, "R7 one done pulse", done_cnt - d0, 1);
        rd(2 * ch, v);
        check(v == exp_lo(val, r10), "R4 result low byte", v, exp_lo(val, r10));
        rd(2 * ch + 1, v);
        check(v == exp_hi, "R6 result high byte", v, exp_hi);
        rd(CTRL0_ADDR, v);
        check(v[4] == 1'b0, "R7 start flag cleared", v[4], 0);
    endtask

    task automatic t_repeat();
        int v, d0;
        bench_res10 = 1'b1;
        analog[5] = 10'h133;
        wr(CTRL1_ADDR, 8'h05);
        wr(CTRL0_ADDR, c0(1, 0, 0, 1, 1, 1));
        d0 = done_cnt;
        wr(CTRL0_ADDR, c0(1, 0, 1, 1, 1, 1));
        idle(110);
        check(busy == 1'b1, "R8 still running", int'(busy), 1);
        rd(10, v); check(v == 'h33, "R8 result lo", v, 'h33);
        rd(11, v); check(v == 1, "R8 result hi", v, 1);
        analog[5] = 10'h0F0;
        idle(70);
        rd(10, v); check(v == 'hF0, "R8 reconverted lo", v, 'hF0);
        rd(11, v); check(v == 0, "R8 reconverted hi", v, 0);
        check(done_cnt == d0, "R8 no done pulse", done_cnt - d0, 0);
        wr(CTRL0_ADDR, c0(1, 0, 0, 1, 1, 1));
        idle(1);
        check(!busy, "R8 stop on flag clear", int'(busy), 0);
    endtask

    task automatic t_sweep();
        int cyc, v, d0;
        bench_res10 = 1'b1;
        for (int k = 0; k < 10; k++) analog[k] = 10'(k * 100 + 7);
        analog[9] = 10'h000;
        wr(CTRL1_ADDR, 8'h09);
        wr(CTRL0_ADDR, c0(2, 0, 0, 1, 1, 1));
        log_n = 0; d0 = done_cnt;
        wr(CTRL0_ADDR, c0(2, 0, 1, 1, 1, 1));
        wait_idle(cyc);
        idle(1);
        check(cyc == 330, "R9 sweep length", cyc, 330);
        check(log_n == 10, "R9 channel count", log_n, 10);
        for (int k = 0; k < 10; k++)
            check(log_ch[k] == k, "R9 ascending order", log_ch[k], k);
        for (int k = 0; k < 10; k++) begin
            rd(2 * k, v);
            check(v == int'(analog[k][7:0]), "R6 sweep lo", v, int'(analog[k][7:0]));
            rd(2 * k + 1, v);
            check(v == int'(analog[k][9:8]), "R6 sweep hi", v, int'(analog[k][9:8]));
        end
        check(done_cnt - d0 == 1, "R9 one done", done_cnt - d0, 1);
        rd(CTRL0_ADDR, v);
        check(v[4] == 1'b0, "R9 flag cleared", v[4], 0);
    endtask

    task automatic t_rsweep(input int mode, input int last, input int n, input int exp [8],
                            input string req);
        int d0;
        wr(CTRL1_ADDR, 8'(last));
        wr(CTRL0_ADDR, c0(mode, 0, 0, 1, 1, 1));
        log_n = 0; d0 = done_cnt;
        wr(CTRL0_ADDR, c0(mode, 0, 1, 1, 1, 1));
        idle(n * 33 + 5);
        wr(CTRL0_ADDR, c0(mode, 0, 0, 1, 1, 1));
        idle(2);
        check(log_n >= n, req, log_n, n);
        for (int k = 0; k < n; k++) check(log_ch[k] == exp[k], req, log_ch[k], exp[k]);
        check(done_cnt == d0, req, done_cnt - d0, 0);
    endtask

    task automatic t_ext();
        int cyc, v, n0, d0;
        bench_res10 = 1'b1;
        analog[2] = 10'h155;
        wr(CTRL1_ADDR, 8'h02);
        wr(CTRL0_ADDR, c0(0, 1, 0, 1, 1, 1));
        n0 = log_n;
        trig_n = 1'b0; idle(4); trig_n = 1'b1; idle(8);
        check(log_n == n0, "R12 edge ignored with flag clear", log_n - n0, 0);
        wr(CTRL0_ADDR, c0(0, 1, 1, 1, 1, 1));
        idle(10);
        check(log_n == n0, "R12 flag write no start", log_n - n0, 0);
        d0 = done_cnt;
        trig_n = 1'b0;
        idle(3);
        check(busy == 1'b1, "R12 triggered start", int'(busy), 1);
        wait_idle(cyc);
        idle(1);
        trig_n = 1'b1;
        rd(4, v); check(v == 'h55, "R12 result", v, 'h55);
        check(done_cnt - d0 == 1, "R12 done", done_cnt - d0, 1);
    endtask

    task automatic t_retrig();
        int cyc, v, d0;
        analog[2] = 10'h0AA;
        wr(CTRL0_ADDR, c0(0, 1, 1, 1, 1, 1));
        idle(4);
        busy_total = 0; d0 = done_cnt;
        trig_n = 1'b0; idle(20);
        trig_n = 1'b1; idle(3);
        trig_n = 1'b0;
        idle(5);
        wait_idle(cyc);
        idle(2);
        trig_n = 1'b1;
        check(busy_total == 23 + 33, "R13 restart length", busy_total, 56);
        check(done_cnt - d0 == 1, "R13 single done", done_cnt - d0, 1);
        rd(4, v); check(v == 'hAA, "R13 result", v, 'hAA);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1-all: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int sw0 [8] = '{0, 1, 2, 0, 1, 2, 0, 0};
        int sw1 [8] = '{0, 1, 0, 2, 0, 3, 0, 1};
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; trig_n = 1'b1;
        bench_res10 = 1'b1;
        for (int k = 0; k < 10; k++) analog[k] = '0;
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_no_vref();
        t_oneshot(1'b1, 1'b0, 0, 3, 10'h2A5, 59, 2);
        t_oneshot(1'b0, 1'b1, 1, 7, 10'h3FF, 56, 0);
        t_oneshot(1'b1, 1'b1, 2, 8, 10'h001, 132, 0);
        t_oneshot(1'b1, 1'b1, 3, 6, 10'h2AA, 132, 2);
        // R5: 8-bit pass keeps the odd byte of channel 3 at 2
        t_oneshot(1'b0, 1'b0, 0, 3, 10'h1F0, 49, 2);
        t_repeat();
        t_sweep();
        t_rsweep(3, 2, 6, sw0, "R10 repeat sweep order");
        t_rsweep(4, 3, 8, sw1, "R11 interleaved order");
        t_ext();
        t_retrig();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule